// File: doc/BRIEF.md
# Data Breakpoint Match Unit

This block compares every data memory access against four programmable breakpoint addresses. An access is given by its first byte address, its length in bytes (1 to 10) and whether it is a write. Each breakpoint covers an aligned window of 1, 2, 4 or 8 bytes. It fires when any byte of the access falls inside that window and its trigger condition accepts the access type. If the access runs past the end of a 64-byte line, it is split. The part above the boundary is compared as well.

When at least one enabled breakpoint fires, the unit raises a one-cycle trap request. In the same cycle it records, in a sticky status word, every breakpoint whose window and condition matched, whether that breakpoint is enabled or not. The status bits build up over a sequence of accesses, such as the iterations of a repeated string move. They clear only when software writes a zero to them. Software writes the breakpoint addresses and the control word through a shared write port, and it reads the control and status words directly.

Top module: `dbm_match_unit`

## Requirements
- R1: After reset, `trap_o` is 0, `ctrl_rdata` is 0 and `stat_rdata` reads 32'hFFFF0FF0: bits 31:16 and 11:4 always read one, bits 15:12 always read zero, and bits 3:0 are the match bits of breakpoints 3..0.
- R2: A breakpoint matches when the access byte range [addr, addr+len-1] overlaps its window. The window starts at the breakpoint address rounded down to the window size. The length field of breakpoint i is control bits [11+4i:10+4i], with codes 00=1, 01=2, 11=4 and 10=8 bytes.
- R3: The condition field of breakpoint i is control bits [9+4i:8+4i]. Code 01 matches only writes and 11 matches reads and writes. Codes 00 (execute) and 10 never match in this unit.
- R4: Control bit i enables breakpoint i. `trap_o` is high for exactly the one cycle after an accepted access in which at least one enabled breakpoint matched. When only disabled breakpoints match, there is no trap and the status does not change.
- R5: When an enabled breakpoint matches, every breakpoint that matched that access, enabled or not, sets its status bit. Matches on breakpoints 0 and 2 read 32'hFFFF0FF5.
- R6: Status bits are sticky. A later access that matches fewer breakpoints leaves the earlier bits set. For example, a match on breakpoint 0 alone after 32'hFFFF0FF5 still reads 32'hFFFF0FF5.
- R7: A status write clears each bit 3:0 that is written as zero and leaves each bit written as one. A hardware set in the same cycle wins over the clear.
- R8: When an access crosses a 64-byte line boundary, the bytes above the boundary are matched as well.
- R9: A 10-byte access matches on all ten bytes, including the ninth and tenth, and also when it crosses a line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | First byte address of the access |
| acc_len | input | 4 | Access length in bytes, 1 to 10 |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| bp_wr | input | 1 | Write `sw_wdata` into breakpoint address `bp_idx` |
| bp_idx | input | 2 | Breakpoint selected by `bp_wr` |
| ctrl_wr | input | 1 | Write `sw_wdata` into the control word |
| stat_wr | input | 1 | Clear the status bits where `sw_wdata` is zero |
| sw_wdata | input | 32 | Software write data |
| ctrl_rdata | output | 32 | Control word |
| stat_rdata | output | 32 | Status word, with its fixed bits applied |
| trap_o | output | 1 | One-cycle debug-trap request |

## Verification
The checks assume that each accepted access has a length between 1 and 10. One check enforces this on the inputs. The checks also assume that the access range does not wrap past the top of the address space, because the overlap compare uses plain magnitude comparisons. The directed tests keep to these limits. Every access the tests present starts well inside the address space, and the lengths used are 1, 2, 8 and 10. Software writes are applied between accesses, except in the one test that deliberately makes a clear and a hardware set coincide.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    typedef enum logic [1:0] {
        COND_EXEC = 2'b00,
        COND_WR   = 2'b01,
        COND_RSVD = 2'b10,
        COND_RW   = 2'b11
    } cond_e;

    typedef struct packed {
        logic       en;
        cond_e      cond;
        logic [1:0] len;
    } bp_cfg_t;

    localparam logic [31:0] STAT_FIXED_ONES = 32'hFFFF0FF0;

    function automatic logic [3:0] window_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd1;
            2'b01:   return 4'd2;
            2'b11:   return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic cond_accepts(input cond_e c, input logic is_write);
        case (c)
            COND_WR: return is_write;
            COND_RW: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbm_splitter.sv
module dbm_splitter #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int LEN_W      = 4
) (
    input  logic [AW-1:0]    addr,
    input  logic [LEN_W-1:0] len,
    output logic [AW-1:0]    lo_start,
    output logic [AW-1:0]    lo_end,
    output logic             hi_valid,
    output logic [AW-1:0]    hi_start,
    output logic [AW-1:0]    hi_end
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [AW-1:0] last_byte;
    logic [AW-1:0] line_last;

    always_comb begin
        last_byte = addr + AW'(len) - AW'(1);
        line_last = {addr[AW-1:OFF_W], {OFF_W{1'b1}}};
        hi_valid  = last_byte > line_last;
        lo_start  = addr;
        lo_end    = hi_valid ? line_last : last_byte;
        hi_start  = line_last + AW'(1);
        hi_end    = last_byte;
    end
endmodule

// File: rtl/dbm_comparator.sv
module dbm_comparator
    import dbm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] bp_addr,
    input  bp_cfg_t       cfg,
    input  logic          is_write,
    input  logic [AW-1:0] lo_start,
    input  logic [AW-1:0] lo_end,
    input  logic          hi_valid,
    input  logic [AW-1:0] hi_start,
    input  logic [AW-1:0] hi_end,
    output logic          addr_hit,
    output logic          armed_hit
);
    logic [AW-1:0] win_size;
    logic [AW-1:0] win_lo;
    logic [AW-1:0] win_hi;
    logic          ov_lo;
    logic          ov_hi;

    always_comb begin
        win_size  = AW'(window_bytes(cfg.len));
        win_lo    = bp_addr & ~(win_size - AW'(1));
        win_hi    = win_lo + win_size - AW'(1);
        ov_lo     = (lo_start <= win_hi) && (win_lo <= lo_end);
        ov_hi     = hi_valid && (hi_start <= win_hi) && (win_lo <= hi_end);
        addr_hit  = (ov_lo || ov_hi) && cond_accepts(cfg.cond, is_write);
        armed_hit = addr_hit && cfg.en;
    end
endmodule

// File: rtl/dbm_status.sv
module dbm_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [N-1:0] set_mask,
    input  logic         clr_en,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] hits_q,
    output logic         trap_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hits_q <= '0;
            trap_q <= 1'b0;
        end else begin
            trap_q <= upd;
            hits_q <= (clr_en ? (hits_q & clr_data) : hits_q) | (upd ? set_mask : '0);
        end
    end

    // A bit may only drop when software wrote a zero to it
    assert_sticky_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (($past(hits_q) & ~hits_q & ~($past(clr_en) ? ~$past(clr_data) : {N{1'b0}})) == '0));

    // A hardware set is never lost, even under a simultaneous clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(upd) && !$past(rst)) |-> (($past(set_mask) & ~hits_q) == '0));

    // A trap always comes with at least one recorded match
    assert_trap_has_status_R5: assert property (@(posedge clk) disable iff (rst)
        trap_q |-> (hits_q != '0));
endmodule

// File: rtl/dbm_match_unit.sv
module dbm_match_unit
    import dbm_pkg::*;
#(
    parameter int NUM_BP     = 4,
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 10,
    parameter int LEN_W      = $clog2(MAX_LEN + 1),
    parameter int IDX_W      = $clog2(NUM_BP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [AW-1:0]    acc_addr,
    input  logic [LEN_W-1:0] acc_len,
    input  logic             acc_write,
    input  logic             bp_wr,
    input  logic [IDX_W-1:0] bp_idx,
    input  logic             ctrl_wr,
    input  logic             stat_wr,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      ctrl_rdata,
    output logic [31:0]      stat_rdata,
    output logic             trap_o
);
    localparam int COND_BASE = 8;
    localparam int FIELD_W   = 4;

    logic [AW-1:0] bp_addr_q [NUM_BP];
    logic [31:0]   ctrl_q;
    bp_cfg_t       cfg [NUM_BP];

    logic [AW-1:0] lo_start, lo_end, hi_start, hi_end;
    logic          hi_valid;
    logic [NUM_BP-1:0] addr_hit;
    logic [NUM_BP-1:0] armed_hit;
    logic          upd;
    logic [NUM_BP-1:0] hits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            for (int i = 0; i < NUM_BP; i++) bp_addr_q[i] <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= sw_wdata;
            if (bp_wr) bp_addr_q[bp_idx] <= sw_wdata[AW-1:0];
        end
    end

    dbm_splitter #(
        .AW(AW), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
    ) u_split (
        .addr(acc_addr), .len(acc_len),
        .lo_start(lo_start), .lo_end(lo_end),
        .hi_valid(hi_valid), .hi_start(hi_start), .hi_end(hi_end)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        always_comb begin
            cfg[g].en   = ctrl_q[g];
            cfg[g].cond = cond_e'(ctrl_q[COND_BASE + FIELD_W*g +: 2]);
            cfg[g].len  = ctrl_q[COND_BASE + FIELD_W*g + 2 +: 2];
        end

        dbm_comparator #(.AW(AW)) u_cmp (
            .bp_addr(bp_addr_q[g]), .cfg(cfg[g]), .is_write(acc_write),
            .lo_start(lo_start), .lo_end(lo_end),
            .hi_valid(hi_valid), .hi_start(hi_start), .hi_end(hi_end),
            .addr_hit(addr_hit[g]), .armed_hit(armed_hit[g])
        );

        // Execute-type breakpoints are never recorded by this unit
        assert_exec_never_sets_R3: assert property (@(posedge clk) disable iff (rst)
            (cfg[g].cond == COND_EXEC && !hits_q[g] && !ctrl_wr) |=> !hits_q[g]);
    end

    assign upd = acc_valid && (|armed_hit);

    dbm_status #(.N(NUM_BP)) u_stat (
        .clk(clk), .rst(rst), .upd(upd), .set_mask(addr_hit),
        .clr_en(stat_wr), .clr_data(sw_wdata[NUM_BP-1:0]),
        .hits_q(hits_q), .trap_q(trap_o)
    );

    assign ctrl_rdata = ctrl_q;
    assign stat_rdata = STAT_FIXED_ONES | 32'(hits_q);

    // Input assumption: access lengths stay within 1..MAX_LEN
    assert_len_legal_R9: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_len >= LEN_W'(1) && acc_len <= LEN_W'(MAX_LEN)));

    // A trap only follows an accepted access
    assert_trap_after_access_R4: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ($past(acc_valid) && !$past(rst)));
endmodule

// File: tb/test_dbm_match_unit.sv
module test_dbm_match_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_len = 4'd1;
    logic        acc_write = 1'b0;
    logic        bp_wr = 1'b0;
    logic [1:0]  bp_idx = '0;
    logic        ctrl_wr = 1'b0;
    logic        stat_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] ctrl_rdata, stat_rdata;
    logic        trap_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dbm_match_unit i_dbm_match_unit (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_len(acc_len), .acc_write(acc_write), .bp_wr(bp_wr), .bp_idx(bp_idx),
        .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .sw_wdata(sw_wdata),
        .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata), .trap_o(trap_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bpcfg(input int i, input bit en,
                                          input logic [1:0] cond, input logic [1:0] len);
        logic [31:0] v;
        v = '0;
        v[i] = en;
        v[8+4*i +: 2]  = cond;
        v[10+4*i +: 2] = len;
        return v;
    endfunction

    task automatic set_bp(input int i, input logic [31:0] a);
        @(negedge clk);
        bp_wr = 1'b1; bp_idx = 2'(i); sw_wdata = a;
        @(negedge clk);
        bp_wr = 1'b0;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1; sw_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_stat(input logic [31:0] v);
        @(negedge clk);
        stat_wr = 1'b1; sw_wdata = v;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic [3:0] l, input logic w,
                          output logic tr, output logic [31:0] st);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_len = l; acc_write = w;
        @(negedge clk);
        tr = trap_o; st = stat_rdata;
        acc_valid = 1'b0;
    endtask

    task automatic test_reset;
        check("R1 trap", 32'(trap_o), 32'd0);
        check("R1 ctrl", ctrl_rdata, 32'h0);
        check("R1 stat", stat_rdata, 32'hFFFF0FF0);
    endtask

    task automatic test_lengths;
        logic t; logic [31:0] s;
        set_bp(0, 32'h1003);
        set_ctrl(bpcfg(0, 1, 2'b11, 2'b11));
        access(32'h1000, 4'd1, 1'b0, t, s);
        check("R2 4B low byte trap", 32'(t), 32'd1);
        check("R2 4B low byte stat", s, 32'hFFFF0FF1);
        write_stat(32'h0);
        access(32'h1004, 4'd1, 1'b0, t, s);
        check("R2 4B past end", {31'd0, t}, 32'd0);
        access(32'h0FFE, 4'd2, 1'b0, t, s);
        check("R2 before window", {31'd0, t}, 32'd0);
        access(32'h0FFF, 4'd2, 1'b0, t, s);
        check("R2 overlap one byte", {31'd0, t}, 32'd1);
        write_stat(32'h0);
        set_bp(0, 32'h2005);
        set_ctrl(bpcfg(0, 1, 2'b11, 2'b10));
        access(32'h2000, 4'd1, 1'b1, t, s);
        check("R2 8B first byte", {31'd0, t}, 32'd1);
        access(32'h2008, 4'd1, 1'b1, t, s);
        check("R2 8B past end", {31'd0, t}, 32'd0);
        write_stat(32'h0);
    endtask

    task automatic test_cond;
        logic t; logic [31:0] s;
        set_bp(1, 32'h3000);
        set_ctrl(bpcfg(1, 1, 2'b01, 2'b00));
        access(32'h3000, 4'd1, 1'b0, t, s);
        check("R3 write-only ignores read", {31'd0, t}, 32'd0);
        access(32'h3000, 4'd1, 1'b1, t, s);
        check("R3 write-only on write", s, 32'hFFFF0FF2);
        write_stat(32'h0);
        set_ctrl(bpcfg(1, 1, 2'b00, 2'b00));
        access(32'h3000, 4'd1, 1'b1, t, s);
        check("R3 exec cond trap", {31'd0, t}, 32'd0);
        check("R3 exec cond stat", s, 32'hFFFF0FF0);
    endtask

    task automatic test_disabled_and_pulse;
        logic t; logic [31:0] s;
        set_bp(2, 32'h3800);
        set_ctrl(bpcfg(2, 0, 2'b11, 2'b00));
        access(32'h3800, 4'd1, 1'b0, t, s);
        check("R4 disabled only trap", {31'd0, t}, 32'd0);
        check("R4 disabled only stat", s, 32'hFFFF0FF0);
        set_ctrl(bpcfg(2, 1, 2'b11, 2'b00));
        access(32'h3800, 4'd1, 1'b0, t, s);
        check("R4 enabled trap", {31'd0, t}, 32'd1);
        @(negedge clk);
        check("R4 trap one cycle", {31'd0, trap_o}, 32'd0);
        write_stat(32'h0);
    endtask

    task automatic test_all_and_sticky;
        logic t; logic [31:0] s;
        set_bp(0, 32'h4000);
        set_bp(2, 32'h4000);
        set_ctrl(bpcfg(0, 1, 2'b11, 2'b11) | bpcfg(2, 0, 2'b11, 2'b00));
        access(32'h4000, 4'd2, 1'b0, t, s);
        check("R5 both reported", s, 32'hFFFF0FF5);
        check("R5 trap", {31'd0, t}, 32'd1);
        access(32'h4002, 4'd1, 1'b0, t, s);
        check("R6 sticky after narrower match", s, 32'hFFFF0FF5);
        check("R6 trap on second", {31'd0, t}, 32'd1);
    endtask

    task automatic test_clear;
        logic [31:0] s;
        write_stat(32'hFFFFFFFB);
        check("R7 selective clear", stat_rdata, 32'hFFFF0FF1);
        set_bp(1, 32'h4800);
        set_ctrl(bpcfg(1, 1, 2'b11, 2'b00));
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h4800; acc_len = 4'd1; acc_write = 1'b0;
        stat_wr = 1'b1; sw_wdata = 32'h0;
        @(negedge clk);
        s = stat_rdata;
        acc_valid = 1'b0; stat_wr = 1'b0;
        check("R7 set wins over clear", s, 32'hFFFF0FF2);
        write_stat(32'h0);
    endtask

    task automatic test_split;
        logic t; logic [31:0] s;
        set_bp(3, 32'h5040);
        set_ctrl(bpcfg(3, 1, 2'b11, 2'b00));
        access(32'h5038, 4'd8, 1'b0, t, s);
        check("R8 no cross miss", {31'd0, t}, 32'd0);
        access(32'h503C, 4'd8, 1'b0, t, s);
        check("R8 upper half hit", s, 32'hFFFF0FF8);
        write_stat(32'h0);
    endtask

    task automatic test_ten_byte;
        logic t; logic [31:0] s;
        set_bp(1, 32'h6009);
        set_ctrl(bpcfg(1, 1, 2'b01, 2'b00));
        access(32'h6000, 4'd10, 1'b1, t, s);
        check("R9 tenth byte", s, 32'hFFFF0FF2);
        write_stat(32'h0);
        set_bp(1, 32'h6008);
        access(32'h6000, 4'd10, 1'b1, t, s);
        check("R9 ninth byte", {31'd0, t}, 32'd1);
        write_stat(32'h0);
        set_bp(1, 32'h600A);
        access(32'h6000, 4'd10, 1'b1, t, s);
        check("R9 beyond tenth", {31'd0, t}, 32'd0);
        set_bp(1, 32'h6083);
        access(32'h607A, 4'd10, 1'b1, t, s);
        check("R9 tenth byte across line", {31'd0, t}, 32'd1);
        write_stat(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_lengths();
        test_cond();
        test_disabled_and_pulse();
        test_all_and_sticky();
        test_clear();
        test_split();
        test_ten_byte();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule